// File: doc/BRIEF.md
# RGMII Transmit Double-Data-Rate Encoder

This block sits between a byte-wide transmit path (eight data bits, an enable and an error flag, one byte per clock) and the reduced-pin RGMII transmit pins. It takes one byte on each rising clock edge and sends it out over a four-bit bus at double data rate. The lower nibble is driven while the clock is high and the upper nibble while the clock is low. A single control pin carries the enable in the high phase and the enable XORed with the error flag in the low phase. A valid frame therefore keeps that pin steady high, and an error shows up only as a low pulse in the low phase.

A two-bit speed input selects byte mode (gigabit) or nibble mode (10 and 100 Mb/s). In nibble mode, only the lower four bits of each transfer are used, and they are repeated on both clock phases. The device clock is forwarded unchanged as the transmit clock. Each phase comes from a register clocked on the edge that opens that phase, and a multiplexer steered by the clock level selects between them. The asynchronous active-low reset is synchronised internally before the registers see it.

Top module: `rgmii_tx_ddr`

## Requirements
- R1: While reset is active, the data pins and the control pin are 0 in both clock phases.
- R2: In byte mode (speed code 2'b10), a byte accepted on a rising edge appears as bits 3:0 in the high phase after that edge and as bits 7:4 in the following low phase.
- R3: In the high phase after a rising edge, the control pin equals the enable accepted on that edge.
- R4: When enable is 1 and error is 0, the control pin is 1 in both phases.
- R5: When enable is 1 and error is 1, the control pin is 1 in the high phase and 0 in the low phase.
- R6: When enable is 0 and error is 0, the control pin is 0 in both phases.
- R7: When enable is 0, the data pins are 0 in both phases whatever the data input holds. With error 1, the control pin is 0 high and 1 low (the XOR rule).
- R8: For speed codes 2'b00, 2'b01 and 2'b11 (nibble mode), bits 3:0 are driven in both phases and bits 7:4 of the input have no effect.
- R9: Each clock accepts a new transfer: consecutive different inputs on consecutive edges each appear in their own clock period.
- R10: The transmit clock output follows the device clock (1 in the high phase, 0 in the low phase).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock; rising edge accepts a transfer |
| rst_n | input | 1 | Asynchronous active-low reset |
| speed_sel | input | 2 | 2'b10 byte mode; other codes nibble mode |
| gmii_txd | input | 8 | Transmit byte |
| gmii_txen | input | 1 | Transmit enable |
| gmii_txer | input | 1 | Transmit error |
| rgmii_txc | output | 1 | Forwarded transmit clock |
| rgmii_txd | output | 4 | Double-data-rate data nibble |
| rgmii_txctl | output | 1 | Double-data-rate control line |

## Verification
Error signalling and data blanking can fall on the same transfer: when enable is 0 and error is 1, the control pin must toggle to 1 in the low phase while the data pins stay 0. Nibble repetition and error encoding can also meet, when an errored transfer is sent at a slow speed code. The bench drives these combinations and samples both phases of the following clock period. Each pin is compared against values derived from the XOR rule and the speed code.

// File: rtl/rgmii_tx_pkg.sv
package rgmii_tx_pkg;
  typedef enum logic [1:0] {
    SPD_10   = 2'b00,
    SPD_100  = 2'b01,
    SPD_1000 = 2'b10,
    SPD_RSVD = 2'b11
  } speed_e;

  function automatic logic is_byte_mode(input speed_e spd);
    return (spd == SPD_1000);
  endfunction
endpackage

// File: rtl/rgmii_tx_rstsync.sv
module rgmii_tx_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/rgmii_tx_capture.sv
module rgmii_tx_capture
  import rgmii_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int NIB_W = DATA_W / 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DATA_W-1:0] txd_in,
  input  logic             en_in,
  input  logic             er_in,
  input  logic [1:0]       speed_in,
  output logic [NIB_W-1:0] rise_d_o,
  output logic             rise_ctl_o,
  output logic [NIB_W-1:0] hold_d_o,
  output logic             hold_ctl_o
);
  logic [NIB_W-1:0] rise_d_q, rise_d_nx, hold_d_q, hold_d_nx;
  logic             rise_ctl_q, rise_ctl_nx, hold_ctl_q, hold_ctl_nx;
  logic             byte_mode;

  assign byte_mode = is_byte_mode(speed_e'(speed_in));

  always_comb begin
    rise_ctl_nx = en_in;
    hold_ctl_nx = en_in ^ er_in;
    rise_d_nx   = '0;
    hold_d_nx   = '0;
    if (en_in) begin
      rise_d_nx = txd_in[NIB_W-1:0];
      hold_d_nx = byte_mode ? txd_in[DATA_W-1:NIB_W] : txd_in[NIB_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_d_q   <= '0;
      rise_ctl_q <= 1'b0;
      hold_d_q   <= '0;
      hold_ctl_q <= 1'b0;
    end else begin
      rise_d_q   <= rise_d_nx;
      rise_ctl_q <= rise_ctl_nx;
      hold_d_q   <= hold_d_nx;
      hold_ctl_q <= hold_ctl_nx;
    end
  end

  assign rise_d_o   = rise_d_q;
  assign rise_ctl_o = rise_ctl_q;
  assign hold_d_o   = hold_d_q;
  assign hold_ctl_o = hold_ctl_q;

  // Checker: armed once one edge has passed since reset
  logic armed_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= 1'b1;
  end

  AST_CTL_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |-> (rise_ctl_q == $past(en_in)));  // R3
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && !$past(en_in)) |-> (rise_d_q == '0 && hold_d_q == '0));  // R7
  AST_NIBBLE_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && $past(speed_in) != 2'b10) |-> (hold_d_q == rise_d_q));  // R8
  AST_ERR_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |-> (hold_ctl_q == ($past(en_in) ^ $past(er_in))));  // R5
endmodule

// File: rtl/rgmii_tx_fallreg.sv
module rgmii_tx_fallreg #(
  parameter int NIB_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NIB_W-1:0] hold_d,
  input  logic             hold_ctl,
  output logic [NIB_W-1:0] fall_d,
  output logic             fall_ctl
);
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fall_d   <= '0;
      fall_ctl <= 1'b0;
    end else begin
      fall_d   <= hold_d;
      fall_ctl <= hold_ctl;
    end
  end

  AST_FALL_FOLLOWS: assert property (@(negedge clk) disable iff (!rst_n)
    (fall_ctl == $past(hold_ctl)) && (fall_d == $past(hold_d)));  // R2
endmodule

// File: rtl/rgmii_tx_ddrmux.sv
module rgmii_tx_ddrmux #(
  parameter int NIB_W = 4
) (
  input  logic             clk,
  input  logic [NIB_W-1:0] rise_d,
  input  logic             rise_ctl,
  input  logic [NIB_W-1:0] fall_d,
  input  logic             fall_ctl,
  output logic [NIB_W-1:0] pin_d,
  output logic             pin_ctl,
  output logic             pin_clk
);
  assign pin_d   = clk ? rise_d : fall_d;
  assign pin_ctl = clk ? rise_ctl : fall_ctl;
  assign pin_clk = clk;
endmodule

// File: rtl/rgmii_tx_ddr.sv
module rgmii_tx_ddr #(
  parameter int DATA_W    = 8,
  parameter int RST_STAGE = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  speed_sel,
  input  logic [7:0]  gmii_txd,
  input  logic        gmii_txen,
  input  logic        gmii_txer,
  output logic        rgmii_txc,
  output logic [3:0]  rgmii_txd,
  output logic        rgmii_txctl
);
  localparam int NIB_W = DATA_W / 2;

  logic             rst_sync_n;
  logic [NIB_W-1:0] rise_d, hold_d, fall_d;
  logic             rise_ctl, hold_ctl, fall_ctl;

  rgmii_tx_rstsync #(.STAGES(RST_STAGE)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  rgmii_tx_capture #(.DATA_W(DATA_W)) u_cap (
    .clk(clk), .rst_n(rst_sync_n),
    .txd_in(gmii_txd), .en_in(gmii_txen), .er_in(gmii_txer), .speed_in(speed_sel),
    .rise_d_o(rise_d), .rise_ctl_o(rise_ctl), .hold_d_o(hold_d), .hold_ctl_o(hold_ctl)
  );

  rgmii_tx_fallreg #(.NIB_W(NIB_W)) u_fall (
    .clk(clk), .rst_n(rst_sync_n),
    .hold_d(hold_d), .hold_ctl(hold_ctl), .fall_d(fall_d), .fall_ctl(fall_ctl)
  );

  rgmii_tx_ddrmux #(.NIB_W(NIB_W)) u_mux (
    .clk(clk), .rise_d(rise_d), .rise_ctl(rise_ctl), .fall_d(fall_d), .fall_ctl(fall_ctl),
    .pin_d(rgmii_txd), .pin_ctl(rgmii_txctl), .pin_clk(rgmii_txc)
  );
endmodule

// File: tb/rgmii_tx_ddr_test.sv
module rgmii_tx_ddr_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] speed_sel;
  logic [7:0] gmii_txd;
  logic       gmii_txen, gmii_txer;
  logic       rgmii_txc, rgmii_txctl;
  logic [3:0] rgmii_txd;
  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  rgmii_tx_ddr uut (
    .clk(clk), .rst_n(rst_n), .speed_sel(speed_sel), .gmii_txd(gmii_txd),
    .gmii_txen(gmii_txen), .gmii_txer(gmii_txer),
    .rgmii_txc(rgmii_txc), .rgmii_txd(rgmii_txd), .rgmii_txctl(rgmii_txctl)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // Drive one transfer from the low phase, then sample both phases of the next period
  task automatic send(input string req, input logic [1:0] spd, input logic [7:0] d,
                      input logic en, input logic er);
    logic [3:0] exp_hi, exp_lo;
    exp_hi = en ? d[3:0] : 4'h0;
    exp_lo = en ? ((spd == 2'b10) ? d[7:4] : d[3:0]) : 4'h0;
    speed_sel = spd; gmii_txd = d; gmii_txen = en; gmii_txer = er;
    @(posedge clk); #5;
    chk({req, " data high phase"}, rgmii_txd, exp_hi);
    chk({req, " ctl high phase R3"}, rgmii_txctl, en);
    chk({req, " clk high R10"}, rgmii_txc, 1);
    @(negedge clk); #5;
    chk({req, " data low phase"}, rgmii_txd, exp_lo);
    chk({req, " ctl low phase"}, rgmii_txctl, en ^ er);
    chk({req, " clk low R10"}, rgmii_txc, 0);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; speed_sel = 2'b10; gmii_txd = 8'hFF; gmii_txen = 1'b1; gmii_txer = 1'b1;
    repeat (2) @(posedge clk);
    #5;
    chk("R1 reset high phase data", rgmii_txd, 0);
    chk("R1 reset high phase ctl", rgmii_txctl, 0);
    @(negedge clk); #5;
    chk("R1 reset low phase data", rgmii_txd, 0);
    chk("R1 reset low phase ctl", rgmii_txctl, 0);
    gmii_txen = 1'b0; gmii_txer = 1'b0;
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk); #5;
  endtask

  task automatic t_gig_frame;
    send("R2 R4 byte A5", 2'b10, 8'hA5, 1'b1, 1'b0);
    send("R2 R4 byte 3C", 2'b10, 8'h3C, 1'b1, 1'b0);
    send("R2 R4 byte FF", 2'b10, 8'hFF, 1'b1, 1'b0);
    send("R2 R4 byte 00", 2'b10, 8'h00, 1'b1, 1'b0);
  endtask

  task automatic t_error;
    send("R5 errored byte 96", 2'b10, 8'h96, 1'b1, 1'b1);
    send("R5 R8 errored nibble", 2'b01, 8'hD2, 1'b1, 1'b1);
  endtask

  task automatic t_idle;
    send("R6 R7 idle with data", 2'b10, 8'hC3, 1'b0, 1'b0);
    send("R7 idle error toggles ctl, data zero", 2'b10, 8'h7E, 1'b0, 1'b1);
    send("R7 idle error nibble mode", 2'b00, 8'h5A, 1'b0, 1'b1);
  endtask

  task automatic t_nibble;
    send("R8 speed 00", 2'b00, 8'hB6, 1'b1, 1'b0);
    send("R8 speed 01", 2'b01, 8'h4E, 1'b1, 1'b0);
    send("R8 speed 11", 2'b11, 8'hF1, 1'b1, 1'b0);
  endtask

  task automatic t_back_to_back;
    for (int i = 0; i < 6; i++) begin
      logic [7:0] b;
      b = 8'(i * 37 + 8'h19);
      send("R9 consecutive bytes", (i % 2 == 0) ? 2'b10 : 2'b01, b, 1'b1, i == 3);
    end
    send("R9 frame end", 2'b10, 8'h81, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_gig_frame();
    t_error();
    t_idle();
    t_nibble();
    t_back_to_back();
    t_reset();
    send("R1 first byte after reset", 2'b10, 8'h6D, 1'b1, 1'b0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule